// File: doc/BRIEF.md
# Addressed Serial Loader for a Quad 12-bit Converter

This block receives 16-bit command words over a three-wire serial link (serial clock, active-low frame enable, data) and routes the 12-bit code in each word into one of four channel holding registers. Each device on a shared link has a two-bit strap address. A word is accepted only when its address field equals the strap. The bits are shifted out again on a serial output so that several devices can be chained.

Behind the four holding registers sits a second rank of four output registers. These drive the converter codes. A low level on the active-low load input copies all holding registers into the output rank together. A low level on the active-low clear input zeroes the output rank. All serial and strobe inputs are asynchronous to the system clock. They are oversampled through two-flop synchronizers, and falling serial-clock edges are found by edge detection.

The serial link has no back-pressure and no valid/ready handshake. The sender owns the pace, and the serial clock must stay low and high for at least four system clocks each.

Top module: `dac_serial_loader`

## Requirements
- R1: A word is 16 bits long and is sent bit 15 first. Bits 1:0 pick the channel (0 to 3, channel n appears at dac_code_o[12n+11:12n]). Bits 3:2 are the device address. Bits 15:4 are the code.
- R2: Data bits are taken only on falling serial-clock edges while fsync_n_i is low. While fsync_n_i is high, serial-clock activity does not change the shift register or sdo_o.
- R3: On the 16th falling edge of a frame, the code is written into the holding register of the selected channel, provided that bits 3:2 equal addr_strap_i.
- R4: When the address field differs from addr_strap_i, no holding register changes.
- R5: sdo_o shows the bit that was shifted in 16 falling edges earlier (0 after reset), whether or not the address matches.
- R6: While load_n_i is low and clear_n_i is high, all four output registers take the holding-register values in the same cycle.
- R7: While clear_n_i is low, all four output registers read zero.
- R8: Clear wins over load. Clear does not touch the holding registers.
- R9: A frame that ends (fsync_n_i high) before 16 falling edges writes nothing. The next frame counts from zero.
- R10: Falling edges after the 16th in the same frame keep shifting toward sdo_o but cause no further write.
- R11: After reset, all holding registers, all output registers and sdo_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| fsync_n_i | input | 1 | Active-low frame enable |
| sdata_i | input | 1 | Serial data in, MSB first |
| addr_strap_i | input | 2 | Device address strap |
| load_n_i | input | 1 | Active-low load of all output registers |
| clear_n_i | input | 1 | Active-low clear of all output registers |
| sdo_o | output | 1 | Serial data out for chaining |
| dac_code_o | output | 48 | Four 12-bit output-register codes, channel 0 in the low bits |

## Verification
The bench aims at the boundary of the 16th edge. A frame cut short at 15 bits must write nothing, and a frame run on to 20 bits must keep the code from the first 16. A counter that fires late or more than once would latch shifted garbage. Words with a mismatched address must still reach sdo_o unchanged but leave every channel alone, and a design that gated the shift path would break the chain. Clear and load are driven together to check that clear wins, and a later load must restore the held codes, which shows that clear did not reach the holding rank.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  localparam int CODE_W = 12;
  localparam int DEV_W  = 2;
  localparam int SEL_W  = 2;
  localparam int WORD_W = CODE_W + DEV_W + SEL_W;
  localparam int CH_NUM = 1 << SEL_W;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [DEV_W-1:0]  dev;
    logic [SEL_W-1:0]  sel;
  } word_t;
endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacld_shifter.sv
module dacld_shifter
  import dacld_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  fs_n_s,
  input  logic  sdi_s,
  output logic  sdo,
  output logic  wr_en,
  output word_t wr_word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              sclk_q;
  logic              fall;
  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] sh_next;

  assign fall    = sclk_q & ~sclk_s;
  assign active  = ~fs_n_s;
  assign sh_next = {shreg[WORD_W-2:0], sdi_s};
  assign sdo     = shreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      wr_en   <= 1'b0;
      wr_word <= '0;
    end else begin
      sclk_q <= sclk_s;
      wr_en  <= 1'b0;
      if (!active) begin
        cnt <= '0;
      end else if (fall) begin
        shreg <= sh_next;
        if (cnt != FULL) cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          wr_en   <= 1'b1;
          wr_word <= word_t'(sh_next);
        end
      end
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(shreg));
  assert_one_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  assert_abandon_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !wr_en);
endmodule

// File: rtl/dacld_latches.sv
module dacld_latches
  import dacld_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  word_t                    wr_word,
  input  logic [DEV_W-1:0]         dev_addr,
  input  logic                     load_n_s,
  input  logic                     clear_n_s,
  output logic [CH_NUM*CODE_W-1:0] codes
);
  logic [CH_NUM-1:0][CODE_W-1:0] in_lat;
  logic [CH_NUM-1:0][CODE_W-1:0] out_lat;
  logic hit;

  assign hit   = wr_en && (wr_word.dev == dev_addr);
  assign codes = out_lat;

  generate
    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          in_lat[c]  <= '0;
          out_lat[c] <= '0;
        end else begin
          if (hit && (wr_word.sel == SEL_W'(c))) in_lat[c] <= wr_word.code;
          if (!clear_n_s) out_lat[c] <= '0;
          else if (!load_n_s) out_lat[c] <= in_lat[c];
        end
      end
    end
  endgenerate

  assert_mismatch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word.dev != dev_addr) |=> $stable(in_lat));
  assert_write_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> in_lat[$past(wr_word.sel)] == $past(wr_word.code));
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n_s |=> out_lat == '0);
  assert_load_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n_s && clear_n_s) |=> out_lat == $past(in_lat));
  assert_clear_spares_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n_s && !wr_en) |=> $stable(in_lat));
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader
  import dacld_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_i,
  input  logic                     fsync_n_i,
  input  logic                     sdata_i,
  input  logic [DEV_W-1:0]         addr_strap_i,
  input  logic                     load_n_i,
  input  logic                     clear_n_i,
  output logic                     sdo_o,
  output logic [CH_NUM*CODE_W-1:0] dac_code_o
);
  logic sclk_s, sdi_s;
  logic fs_n_s, load_n_s, clear_n_s;
  logic  wr_en;
  word_t wr_word;

  dacld_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) i_sync_lo (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_i, sdata_i}), .q({sclk_s, sdi_s})
  );

  dacld_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) i_sync_hi (
    .clk(clk), .rst_n(rst_n),
    .d({fsync_n_i, load_n_i, clear_n_i}), .q({fs_n_s, load_n_s, clear_n_s})
  );

  dacld_shifter i_shifter (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .fs_n_s(fs_n_s), .sdi_s(sdi_s),
    .sdo(sdo_o), .wr_en(wr_en), .wr_word(wr_word)
  );

  dacld_latches i_latches (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_word(wr_word), .dev_addr(addr_strap_i),
    .load_n_s(load_n_s), .clear_n_s(clear_n_s),
    .codes(dac_code_o)
  );
endmodule

// File: tb/test_dac_serial_loader.sv
module test_dac_serial_loader;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, fs_n = 1'b1, sdata = 1'b0;
  logic [1:0] strap = 2'b10;
  logic load_n = 1'b1, clear_n = 1'b1;
  logic sdo;
  logic [47:0] codes;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] sh_m = '0;
  logic [11:0] in_m [4];
  logic [11:0] out_m [4];

  always #2.5 clk = ~clk;

  dac_serial_loader i_dac_serial_loader (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fsync_n_i(fs_n), .sdata_i(sdata),
    .addr_strap_i(strap), .load_n_i(load_n), .clear_n_i(clear_n),
    .sdo_o(sdo), .dac_code_o(codes)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    for (int c = 0; c < 4; c++) chk(req, 32'(codes[c*12 +: 12]), 32'(out_m[c]));
  endtask

  // Sends nbits bits, MSB first, with fsync held at fs_level; the model
  // mirrors R2, R3, R4, R5, R9 and R10.
  task automatic send(input logic [31:0] bits, input int nbits, input logic fs_level);
    logic [15:0] w;
    fs_n = fs_level;
    tick(4);
    for (int k = 0; k < nbits; k++) begin
      sdata = bits[nbits-1-k];
      tick(H);
      sclk = 1'b1;
      tick(H);
      sclk = 1'b0;
      tick(H);
      if (!fs_level) begin
        sh_m = {sh_m[14:0], bits[nbits-1-k]};
        if (k == 15) begin
          w = sh_m;
          if (w[3:2] == strap) in_m[w[1:0]] = w[15:4];
        end
      end
      chk("R5 sdo", 32'(sdo), 32'(sh_m[15]));
    end
    fs_n = 1'b1;
    tick(6);
  endtask

  task automatic do_load();
    load_n = 1'b0; tick(6); load_n = 1'b1; tick(4);
    for (int c = 0; c < 4; c++) out_m[c] = in_m[c];
    check_outs("R6 load");
  endtask

  task automatic do_clear();
    clear_n = 1'b0; tick(6);
    for (int c = 0; c < 4; c++) out_m[c] = '0;
    check_outs("R7 clear");
    clear_n = 1'b1; tick(4);
  endtask

  function automatic logic [15:0] mkword(input logic [11:0] code, input logic [1:0] dev,
                                         input logic [1:0] sel);
    return {code, dev, sel};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 4; c++) begin in_m[c] = '0; out_m[c] = '0; end
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R11 reset state
    check_outs("R11 reset");
    chk("R11 sdo", 32'(sdo), 0);
    do_load();

    // R1/R3 directed: one word per channel, address matches
    for (int c = 0; c < 4; c++) send(32'(mkword(12'hA50 + 12'(c), strap, 2'(c))), 16, 1'b0);
    do_load();
    // R4 mismatch: nothing changes, sdo still carries the word (R5)
    send(32'(mkword(12'hFFF, ~strap, 2'd1)), 16, 1'b0);
    do_load();
    // R2 clocks with fsync high shift nothing
    send(32'hFFFF, 16, 1'b1);
    do_load();
    // R9 abandoned frame at 15 bits, then full frame counts from zero
    send(32'(mkword(12'h123, strap, 2'd2)) >> 1, 15, 1'b0);
    do_load();
    send(32'(mkword(12'h3C3, strap, 2'd2)), 16, 1'b0);
    do_load();
    // R10 extra edges after the 16th
    send({mkword(12'h777, strap, 2'd3), 4'b1011}, 20, 1'b0);
    do_load();
    // R7 clear, R8 input latches survive clear, clear wins over load
    do_clear();
    clear_n = 1'b0; load_n = 1'b0; tick(6);
    check_outs("R8 clear over load");
    clear_n = 1'b1; load_n = 1'b1; tick(4);
    check_outs("R8 after release");
    do_load();

    // Random frames
    for (int i = 0; i < 40; i++) begin
      logic [15:0] w;
      int extra;
      w = 16'($urandom);
      if ($urandom % 2 == 0) w[3:2] = strap;
      extra = int'($urandom % 4);
      case ($urandom % 8)
        0: send(32'(w) >> 3, 13, 1'b0);
        default: send((32'(w) << extra) | 32'($urandom % (1 << extra)), 16 + extra, 1'b0);
      endcase
      if ($urandom % 3 == 0) do_load();
      if ($urandom % 9 == 0) do_clear();
    end
    do_load();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule